// File: doc/BRIEF.md
# Four-Channel DMA Register Programming Port

This block is the processor-facing register file of a four-channel DMA controller. A host writes and reads it over an 8-bit data bus with an active-low select, separate read and write strobes and a 4-bit register address. Each channel holds a 16-bit transfer address, a 16-bit transfer count and a 6-bit mode field. One byte pointer, shared by all channels, decides whether a byte access reaches the low half or the high half of a 16-bit register. The pointer flips after every such access, so software writes the low byte and then the high byte through the same port.

The block also holds the global registers: a command byte, software request bits, per-channel mask bits, latched terminal-count status and a temporary data byte. Three ports act as commands whatever the data bus carries: reset the byte pointer, perform a master clear, and unmask every channel. The transfer sequencer outside this block reads the programmed values from wide output buses. It reports terminal-count pulses, live request lines and temporary-byte loads back into the block. Read data is registered and returned with a valid flag one cycle after the read strobe.

Top module: `dma_regport`

## Requirements
- R1: Channel registers sit at addresses 0 to 7. Bits 2:1 of the address select the channel, and bit 0 picks the transfer address (0) or the transfer count (1). A write goes to the low byte when the byte pointer is 0 and to the high byte when it is 1. Channel n appears on `ch_addr[16n+15:16n]` and `ch_count[16n+15:16n]`.
- R2: Every selected read or write of a channel register flips the byte pointer. A read returns the byte that the pointer selects before it flips.
- R3: A write to address 0xC sets the byte pointer to 0 whatever data is on the bus.
- R4: Reset and a write to address 0xD (master clear, data ignored) each clear the command byte, the terminal-count status, the software requests, the temporary byte and the byte pointer, and set all four mask bits. A master clear leaves channel addresses and counts as they are.
- R5: A write to address 0xE clears all four mask bits whatever data is on the bus.
- R6: A write to address 0xA changes one mask bit. Data bits 1:0 give the channel, and bit 2 sets the mask (1) or clears it (0). A write to 0xF loads all four masks from data bits 3:0, and a read of 0xF returns the masks in bits 3:0.
- R7: A write to address 0xB selects a channel with data bits 1:0 and stores data bits 7:2 in that channel's mode field, `ch_mode[6n+5:6n]`. The other channels' mode fields do not change.
- R8: A write to address 0x9 selects a channel with data bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) that channel's software request, `sw_req[n]`.
- R9: A read of address 0x8 returns the terminal-count flags in bits 3:0 and `req_line | sw_req` in bits 7:4. A pulse on `tc_pulse[n]` latches flag n. The status read clears the flags, except that a pulse arriving in the same cycle as the read stays latched.
- R10: A write to address 0x8 stores the command byte on `cmd_reg`. Bit 0 of that byte enables memory-to-memory transfers.
- R11: `tmp_we` loads `tmp_data` into the temporary byte, and a read of address 0xD returns it.
- R12: When `cs_n` is high, reads and writes have no effect and produce no read data. A selected read sets `rvalid` with the data in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low block select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid |
| tc_pulse | input | 4 | Terminal-count pulses from the sequencer |
| req_line | input | 4 | Live request lines of the channels |
| tmp_we | input | 1 | Temporary byte load strobe |
| tmp_data | input | 8 | Temporary byte value |
| ch_addr | output | 64 | Transfer address of each channel |
| ch_count | output | 64 | Transfer count of each channel |
| ch_mode | output | 24 | Mode field of each channel |
| cmd_reg | output | 8 | Command byte |
| sw_req | output | 4 | Software request bits |
| ch_mask | output | 4 | Channel mask bits |

## Verification
Every write and every register effect of an access, including the pointer flip and the status clear, takes hold at the rising edge that samples the strobe. The new value is visible at the next falling edge. Read data and `rvalid` come out of a register one rising edge after the read strobe. The bench drives each access for exactly one cycle between falling edges. It checks output buses at the falling edge that ends the access, and a monitor pops the expected byte from the scoreboard queue at the falling edge where `rvalid` is high. A read that returns nothing, or an unexpected `rvalid`, is therefore reported as a failure.

// File: rtl/dma_regport_pkg.sv
package dma_regport_pkg;
  localparam int NCH  = 4;
  localparam int DW   = 8;
  localparam int RW   = 2 * DW;
  localparam int CHW  = $clog2(NCH);
  localparam int MODW = DW - CHW;

  localparam logic [3:0] A_CMD_STAT = 4'h8;
  localparam logic [3:0] A_REQ      = 4'h9;
  localparam logic [3:0] A_MASK1    = 4'hA;
  localparam logic [3:0] A_MODE     = 4'hB;
  localparam logic [3:0] A_CLRPTR   = 4'hC;
  localparam logic [3:0] A_MCLR_TMP = 4'hD;
  localparam logic [3:0] A_CLRMASK  = 4'hE;
  localparam logic [3:0] A_MASKALL  = 4'hF;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regport_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_we,
  input  logic            cnt_we,
  input  logic            mode_we,
  input  logic            hi_sel,
  input  logic [DW-1:0]   wdata,
  output logic [RW-1:0]   cur_addr,
  output logic [RW-1:0]   cur_cnt,
  output logic [MODW-1:0] mode
);
  logic [RW-1:0]   addr_d, cnt_d;
  logic [MODW-1:0] mode_d;

  always_comb begin
    addr_d = cur_addr;
    cnt_d  = cur_cnt;
    mode_d = mode;
    if (addr_we) begin
      if (hi_sel) addr_d[RW-1:DW] = wdata;
      else        addr_d[DW-1:0]  = wdata;
    end
    if (cnt_we) begin
      if (hi_sel) cnt_d[RW-1:DW] = wdata;
      else        cnt_d[DW-1:0]  = wdata;
    end
    if (mode_we) mode_d = wdata[DW-1:CHW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      mode     <= '0;
    end else begin
      if (addr_we) cur_addr <= addr_d;
      if (cnt_we)  cur_cnt  <= cnt_d;
      if (mode_we) mode     <= mode_d;
    end
  end

  // R1
  low_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !hi_sel) |=> (cur_addr[DW-1:0] == $past(wdata)));

  // R1
  high_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && hi_sel) |=> (cur_cnt[RW-1:DW] == $past(wdata)));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regport_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide_acc,
  input  logic           clr_ptr,
  input  logic           mclr,
  input  logic           clr_mask,
  input  logic           wr_mask1,
  input  logic           wr_maskall,
  input  logic           wr_req,
  input  logic           wr_cmd,
  input  logic           rd_status,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] tc_pulse,
  input  logic           tmp_we,
  input  logic [DW-1:0]  tmp_data,
  output logic           ptr_q,
  output logic [DW-1:0]  cmd_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] req_q,
  output logic [NCH-1:0] tc_q,
  output logic [DW-1:0]  tmp_q
);
  logic           ptr_d;
  logic [DW-1:0]  cmd_d, tmp_d;
  logic [NCH-1:0] mask_d, req_d, tc_d;
  logic [CHW-1:0] sel_ch;

  assign sel_ch = wdata[CHW-1:0];

  always_comb begin
    ptr_d  = ptr_q;
    cmd_d  = cmd_q;
    mask_d = mask_q;
    req_d  = req_q;
    tc_d   = (rd_status ? '0 : tc_q) | tc_pulse;
    tmp_d  = tmp_we ? tmp_data : tmp_q;
    if (clr_ptr)       ptr_d = 1'b0;
    else if (wide_acc) ptr_d = ~ptr_q;
    if (wr_cmd) cmd_d = wdata;
    if (clr_mask)        mask_d = '0;
    else if (wr_maskall) mask_d = wdata[NCH-1:0];
    else if (wr_mask1)   mask_d[sel_ch] = wdata[CHW];
    if (wr_req) req_d[sel_ch] = wdata[CHW];
    if (mclr) begin
      ptr_d  = 1'b0;
      cmd_d  = '0;
      mask_d = '1;
      req_d  = '0;
      tc_d   = '0;
      tmp_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      tmp_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      cmd_q  <= cmd_d;
      mask_q <= mask_d;
      req_q  <= req_d;
      tc_q   <= tc_d;
      tmp_q  <= tmp_d;
    end
  end

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_acc && !mclr && !clr_ptr) |=> (ptr_q != $past(ptr_q)));

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr |=> !ptr_q);

  // R4
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1 && cmd_q == '0 && tc_q == '0 && req_q == '0 && tmp_q == '0 && !ptr_q));

  // R5
  unmask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask && !mclr) |=> (mask_q == '0));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && tc_pulse == '0) |=> (tc_q == '0));
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  input  logic [NCH-1:0]    tc_pulse,
  input  logic [NCH-1:0]    req_line,
  input  logic              tmp_we,
  input  logic [DW-1:0]     tmp_data,
  output logic [NCH*RW-1:0] ch_addr,
  output logic [NCH*RW-1:0] ch_count,
  output logic [NCH*MODW-1:0] ch_mode,
  output logic [DW-1:0]     cmd_reg,
  output logic [NCH-1:0]    sw_req,
  output logic [NCH-1:0]    ch_mask
);
  logic           acc_rd, acc_wr, is_chan, is_cnt, wide_acc, ptr;
  logic [CHW-1:0] ch_sel;
  logic           wr_cmd, wr_req, wr_mask1, wr_mode, clr_ptr, mclr, clr_mask, wr_maskall, rd_status;
  logic [NCH-1:0] tc_bits;
  logic [DW-1:0]  tmp_byte, rdata_d;
  logic [RW-1:0]  sel_word;

  assign acc_rd   = !cs_n && rd;
  assign acc_wr   = !cs_n && wr;
  assign is_chan  = !addr[3];
  assign is_cnt   = addr[0];
  assign ch_sel   = addr[CHW:1];
  assign wide_acc = is_chan && (acc_rd || acc_wr);

  assign wr_cmd     = acc_wr && addr == A_CMD_STAT;
  assign rd_status  = acc_rd && addr == A_CMD_STAT;
  assign wr_req     = acc_wr && addr == A_REQ;
  assign wr_mask1   = acc_wr && addr == A_MASK1;
  assign wr_mode    = acc_wr && addr == A_MODE;
  assign clr_ptr    = acc_wr && addr == A_CLRPTR;
  assign mclr       = acc_wr && addr == A_MCLR_TMP;
  assign clr_mask   = acc_wr && addr == A_CLRMASK;
  assign wr_maskall = acc_wr && addr == A_MASKALL;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic hit;
      assign hit = acc_wr && is_chan && (ch_sel == CHW'(g));
      dma_chan_regs u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_we  (hit && !is_cnt),
        .cnt_we   (hit && is_cnt),
        .mode_we  (wr_mode && wdata[CHW-1:0] == CHW'(g)),
        .hi_sel   (ptr),
        .wdata    (wdata),
        .cur_addr (ch_addr[g*RW +: RW]),
        .cur_cnt  (ch_count[g*RW +: RW]),
        .mode     (ch_mode[g*MODW +: MODW])
      );
    end
  endgenerate

  dma_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_acc   (wide_acc),
    .clr_ptr    (clr_ptr),
    .mclr       (mclr),
    .clr_mask   (clr_mask),
    .wr_mask1   (wr_mask1),
    .wr_maskall (wr_maskall),
    .wr_req     (wr_req),
    .wr_cmd     (wr_cmd),
    .rd_status  (rd_status),
    .wdata      (wdata),
    .tc_pulse   (tc_pulse),
    .tmp_we     (tmp_we),
    .tmp_data   (tmp_data),
    .ptr_q      (ptr),
    .cmd_q      (cmd_reg),
    .mask_q     (ch_mask),
    .req_q      (sw_req),
    .tc_q       (tc_bits),
    .tmp_q      (tmp_byte)
  );

  assign sel_word = is_cnt ? ch_count[ch_sel*RW +: RW] : ch_addr[ch_sel*RW +: RW];

  always_comb begin
    rdata_d = '0;
    if (is_chan) rdata_d = ptr ? sel_word[RW-1:DW] : sel_word[DW-1:0];
    else begin
      case (addr)
        A_CMD_STAT: rdata_d = {req_line | sw_req, tc_bits};
        A_MCLR_TMP: rdata_d = tmp_byte;
        A_MASKALL:  rdata_d = {{(DW-NCH){1'b0}}, ch_mask};
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= acc_rd;
      if (acc_rd) rdata <= rdata_d;
    end
  end

  // R12
  no_select_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !rvalid);

  // R12
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rvalid);
endmodule

// File: tb/tb_dma_regport.sv
module tb_dma_regport;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd = 1'b0, wr = 1'b0, tmp_we = 1'b0;
  logic [3:0]  addr = '0, tc_pulse = '0, req_line = '0;
  logic [7:0]  wdata = '0, tmp_data = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [63:0] ch_addr, ch_count;
  logic [23:0] ch_mode;
  logic [7:0]  cmd_reg;
  logic [3:0]  sw_req, ch_mask;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  dma_regport dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .tc_pulse(tc_pulse), .req_line(req_line),
    .tmp_we(tmp_we), .tmp_data(tmp_data), .ch_addr(ch_addr), .ch_count(ch_count),
    .ch_mode(ch_mode), .cmd_reg(cmd_reg), .sw_req(sw_req), .ch_mask(ch_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected byte per returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R12 unexpected rvalid", 64'(rdata), 64'hx);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, 64'(rdata), 64'(e));
      end
    end
  end

  task automatic access(input logic sel, input logic is_wr, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = !sel; wr = is_wr; rd = !is_wr; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    access(1'b1, 1'b1, a, d);
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    access(1'b1, 1'b0, a, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state R4
    chk("R4 reset mask", 64'(ch_mask), 64'hF);
    chk("R4 reset cmd", 64'(cmd_reg), 64'h0);
    rd_reg(4'h8, 8'h00, "R9 reset status");

    // R1 byte writes via pointer
    wr_reg(4'h0, 8'h34); wr_reg(4'h0, 8'h12);
    chk("R1 ch0 address", 64'(ch_addr[15:0]), 64'h1234);
    wr_reg(4'h5, 8'hCD); wr_reg(4'h5, 8'hAB);
    chk("R1 ch2 count", 64'(ch_count[47:32]), 64'hABCD);
    // R2 reads flip pointer
    rd_reg(4'h0, 8'h34, "R2 read low byte");
    rd_reg(4'h5, 8'hAB, "R2 read high byte after flip");
    // R3 clear pointer ignores data
    wr_reg(4'h0, 8'h99);
    wr_reg(4'hC, 8'hFF);
    rd_reg(4'h0, 8'h99, "R3 pointer cleared");
    wr_reg(4'hC, 8'h00);

    // R7 mode
    wr_reg(4'hB, 8'hA7);
    chk("R7 ch3 mode", 64'(ch_mode[23:18]), 64'h29);
    chk("R7 others unchanged", 64'(ch_mode[17:0]), 64'h0);

    // R10 command
    wr_reg(4'h8, 8'h01);
    chk("R10 memory-to-memory bit", 64'(cmd_reg[0]), 64'h1);

    // R8 software request
    wr_reg(4'h9, 8'h06);
    chk("R8 set request", 64'(sw_req), 64'h4);
    wr_reg(4'h9, 8'h02);
    chk("R8 clear request", 64'(sw_req), 64'h0);

    // R5 / R6 masks
    wr_reg(4'hE, 8'hFF);
    chk("R5 clear all masks", 64'(ch_mask), 64'h0);
    wr_reg(4'hA, 8'h05);
    chk("R6 set mask ch1", 64'(ch_mask), 64'h2);
    wr_reg(4'hA, 8'h01);
    chk("R6 clear mask ch1", 64'(ch_mask), 64'h0);
    wr_reg(4'hF, 8'hFA);
    chk("R6 all-mask write", 64'(ch_mask), 64'hA);
    rd_reg(4'hF, 8'h0A, "R6 mask readback");

    // R9 status
    @(negedge clk); tc_pulse = 4'b0010; req_line = 4'b1000;
    @(negedge clk); tc_pulse = 4'b0000;
    rd_reg(4'h8, 8'h82, "R9 status flags");
    rd_reg(4'h8, 8'h80, "R9 flags cleared by read");

    // R11 temporary byte
    @(negedge clk); tmp_we = 1'b1; tmp_data = 8'h5A;
    @(negedge clk); tmp_we = 1'b0;
    rd_reg(4'hD, 8'h5A, "R11 temp readback");

    // R12 unselected access ignored
    access(1'b0, 1'b1, 4'h8, 8'h55);
    chk("R12 unselected write ignored", 64'(cmd_reg), 64'h01);
    access(1'b0, 1'b0, 4'h8, 8'h00);

    // R4 master clear
    req_line = 4'b0000;
    wr_reg(4'h9, 8'h04);
    @(negedge clk); tc_pulse = 4'b0100;
    @(negedge clk); tc_pulse = 4'b0000;
    wr_reg(4'h0, 8'h77);
    wr_reg(4'hD, 8'h3C);
    chk("R4 master clear mask", 64'(ch_mask), 64'hF);
    chk("R4 master clear cmd", 64'(cmd_reg), 64'h0);
    chk("R4 master clear request", 64'(sw_req), 64'h0);
    chk("R4 address kept", 64'(ch_addr[15:0]), 64'h1277);
    rd_reg(4'h8, 8'h00, "R4 status cleared");
    rd_reg(4'hD, 8'h00, "R4 temp cleared");
    rd_reg(4'h0, 8'h77, "R4 pointer cleared");

    repeat (3) @(negedge clk);
    chk("R12 all reads returned", 64'(exp_q.size()), 64'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule